// File: doc/BRIEF.md
# GPIO Port with Per-Pin Function Select

This block is a small memory-mapped general-purpose I/O port. Every pin carries a three-bit function code: plain input, software-driven output, or one of six alternate functions. In an alternate mode the block routes that peripheral's drive value and enable to the pad. Software cannot write the output value directly. It changes the output latch only by writing ones to a set register, which raises pins, or to a clear register, which lowers them. Bits written as zero leave their pins as they were. As a result, two agents can update disjoint pins without a read-modify-write.

The pad side gives a data value, an output enable and separate pull-up and pull-down requests for each pin. It also gives a one-hot select that tells each alternate peripheral which pin it owns. Incoming pad levels pass through a two-flop synchronizer. Software reads them as a packed level word, or one pin at a time through a per-pin window that returns the level in bit 0. The CPU side is a single-cycle request bus with registered read data.

Top module: `gpio_fsel_port`

## Requirements
- R1: In reset and right after it, every pin is in input mode with output enable low, the output latch is 0, no pull is requested, no alternate select is active, and read data and read valid are 0.
- R2: Function codes are 3 bits per pin. Ten pins are packed into each word from word address 0, with pin p at word p/10, bits 3*(p%10)+2..3*(p%10). Bits 30 and 31, and fields of pins that do not exist, read as 0. Code 0 is input and code 1 is output.
- R3: A write to word address 8 sets the output latch bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R4: A write to word address 9 clears the output latch bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R5: A pin in input mode has output enable 0. A pin in output mode has output enable 1 and drives its latch value.
- R6: The output latch changes only through address 8 and address 9 writes, including while a pin is in input mode. Switching a pin to output therefore drives the last value that was set or cleared.
- R7: Code 2+k (k = 0..5) selects alternate function k. Select bit p*6+k is 1, and the pad output and enable come from the alternate inputs at index p*6+k. Pins not in an alternate mode assert no select bit.
- R8: Word address 10 returns the pad levels after a two-flop synchronizer. A read whose sampling edge is the second edge after a pad change still returns the old level. A read one edge later returns the new level.
- R9: Word address 32+p returns the synchronized level of pin p in bit 0, with all other bits 0.
- R10: Pull codes are 2 bits per pin. Sixteen pins are packed into each word from word address 12, with pin p at word 12+p/16, bits 2*(p%16)+1..2*(p%16). Code 1 requests pull-down, code 2 requests pull-up, and codes 0 and 3 request none. The fields read back as written.
- R11: Reads of addresses 8 and 9, and of unmapped addresses, return 0.
- R12: Read data and read valid appear on the cycle after a read request. Read valid is high for exactly that cycle. Read data is 0 whenever read valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid |
| pad_in_i | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out_o | output | NUM_PINS | Pad output value |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pad_pu_o | output | NUM_PINS | Pull-up request |
| pad_pd_o | output | NUM_PINS | Pull-down request |
| alt_sel_o | output | NUM_PINS*6 | One-hot owner select per pin and alternate function |
| alt_out_i | input | NUM_PINS*6 | Alternate-function output values |
| alt_oe_i | input | NUM_PINS*6 | Alternate-function output enables |

## Verification
The bench builds the port with its defaults, 18 pins and an 8-bit address. With that setting the second function-select word and the second pull word are only partly filled, so the bench reaches the zero-reading unused fields. The per-pin window also ends below its address range, so a read just past the last pin is possible. Each pin is swept through all eight function codes and all four pull codes in rotating combinations. Walking-one set and clear writes cover every latch bit, and timed level reads pin down the synchronizer latency edge by edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W        = 32;
  localparam int FSEL_W        = 3;
  localparam int NUM_ALT       = 6;
  localparam int PINS_PER_FSEL = 10;
  localparam int PULL_W        = 2;
  localparam int PINS_PER_PULL = 16;

  localparam int ADDR_FSEL = 0;
  localparam int ADDR_SET  = 8;
  localparam int ADDR_CLR  = 9;
  localparam int ADDR_LEV  = 10;
  localparam int ADDR_PULL = 12;
  localparam int ADDR_PIN  = 32;

  typedef enum logic [FSEL_W-1:0] {
    FSEL_IN   = 3'd0,
    FSEL_OUT  = 3'd1,
    FSEL_ALT0 = 3'd2,
    FSEL_ALT1 = 3'd3,
    FSEL_ALT2 = 3'd4,
    FSEL_ALT3 = 3'd5,
    FSEL_ALT4 = 3'd6,
    FSEL_ALT5 = 3'd7
  } fsel_e;

  typedef enum logic [PULL_W-1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [WIDTH-1:0] meta_q, sync_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din_i;
      sync_q <= meta_q;
    end
  end

  assign dout_o = sync_q;

  // history depth tracker for the latency check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  p_two_flop_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (dout_o == $past(din_i, 2)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int ADDR_W   = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bus_req_i,
  input  logic                         bus_we_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [DATA_W-1:0]            bus_wdata_i,
  output logic [DATA_W-1:0]            bus_rdata_o,
  output logic                         bus_rvalid_o,
  input  logic [NUM_PINS-1:0]          level_i,
  output logic [NUM_PINS*FSEL_W-1:0]   fsel_o,
  output logic [NUM_PINS-1:0]          out_o,
  output logic [NUM_PINS*PULL_W-1:0]   pull_o
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(ADDR_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADDR_CLR);
  localparam logic [ADDR_W-1:0] A_LEV = ADDR_W'(ADDR_LEV);

  fsel_e               fsel_q [NUM_PINS];
  pull_e               pull_q [NUM_PINS];
  logic [NUM_PINS-1:0] out_q;
  logic [DATA_W-1:0]   rd_word, rdata_q;
  logic                rvalid_q;
  logic                wr, rd;

  assign wr = bus_req_i &  bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        fsel_q[p] <= FSEL_IN;
        pull_q[p] <= PULL_NONE;
      end
      out_q <= '0;
    end else if (wr) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bus_addr_i == ADDR_W'(ADDR_FSEL + p / PINS_PER_FSEL))
          fsel_q[p] <= fsel_e'(bus_wdata_i[FSEL_W*(p%PINS_PER_FSEL) +: FSEL_W]);
        if (bus_addr_i == ADDR_W'(ADDR_PULL + p / PINS_PER_PULL))
          pull_q[p] <= pull_e'(bus_wdata_i[PULL_W*(p%PINS_PER_PULL) +: PULL_W]);
      end
      if (bus_addr_i == A_SET) out_q <= out_q |  bus_wdata_i[NUM_PINS-1:0];
      if (bus_addr_i == A_CLR) out_q <= out_q & ~bus_wdata_i[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr_i == ADDR_W'(ADDR_FSEL + p / PINS_PER_FSEL))
        rd_word[FSEL_W*(p%PINS_PER_FSEL) +: FSEL_W] = fsel_q[p];
      if (bus_addr_i == ADDR_W'(ADDR_PULL + p / PINS_PER_PULL))
        rd_word[PULL_W*(p%PINS_PER_PULL) +: PULL_W] = pull_q[p];
      if (bus_addr_i == ADDR_W'(ADDR_PIN + p))
        rd_word[0] = level_i[p];
    end
    if (bus_addr_i == A_LEV) rd_word[NUM_PINS-1:0] = level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      rdata_q  <= rd ? rd_word : '0;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      fsel_o[FSEL_W*p +: FSEL_W] = fsel_q[p];
      pull_o[PULL_W*p +: PULL_W] = pull_q[p];
    end
  end
  assign out_o = out_q;

  p_set_raises_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_SET) |=>
      ((out_q & $past(bus_wdata_i[NUM_PINS-1:0])) == $past(bus_wdata_i[NUM_PINS-1:0])));
  p_set_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_SET) |=>
      ((out_q & ~$past(bus_wdata_i[NUM_PINS-1:0])) == ($past(out_q) & ~$past(bus_wdata_i[NUM_PINS-1:0]))));
  p_clr_lowers_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_CLR) |=> ((out_q & $past(bus_wdata_i[NUM_PINS-1:0])) == '0));
  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (bus_addr_i == A_SET || bus_addr_i == A_CLR)) |=> $stable(out_q));
  p_wo_reads_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (bus_addr_i == A_SET || bus_addr_i == A_CLR)) |=> (bus_rdata_o == '0));
  p_rvalid_follows_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> bus_rvalid_o);
  p_idle_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (!bus_rvalid_o && bus_rdata_o == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 18
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PINS*FSEL_W-1:0]    fsel_i,
  input  logic [NUM_PINS-1:0]           out_i,
  input  logic [NUM_PINS*PULL_W-1:0]    pull_i,
  input  logic [NUM_PINS*NUM_ALT-1:0]   alt_out_i,
  input  logic [NUM_PINS*NUM_ALT-1:0]   alt_oe_i,
  output logic [NUM_PINS-1:0]           pad_out_o,
  output logic [NUM_PINS-1:0]           pad_oe_o,
  output logic [NUM_PINS-1:0]           pad_pu_o,
  output logic [NUM_PINS-1:0]           pad_pd_o,
  output logic [NUM_PINS*NUM_ALT-1:0]   alt_sel_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    fsel_e              mode;
    pull_e              pull;
    logic [NUM_ALT-1:0] sel, a_out, a_oe;

    assign mode  = fsel_e'(fsel_i[FSEL_W*g +: FSEL_W]);
    assign pull  = pull_e'(pull_i[PULL_W*g +: PULL_W]);
    assign a_out = alt_out_i[NUM_ALT*g +: NUM_ALT];
    assign a_oe  = alt_oe_i[NUM_ALT*g +: NUM_ALT];

    always_comb begin
      for (int k = 0; k < NUM_ALT; k++)
        sel[k] = (mode == fsel_e'(FSEL_ALT0 + 3'(k)));
    end

    always_comb begin
      unique case (mode)
        FSEL_IN: begin
          pad_out_o[g] = out_i[g];
          pad_oe_o[g]  = 1'b0;
        end
        FSEL_OUT: begin
          pad_out_o[g] = out_i[g];
          pad_oe_o[g]  = 1'b1;
        end
        default: begin
          pad_out_o[g] = |(sel & a_out);
          pad_oe_o[g]  = |(sel & a_oe);
        end
      endcase
    end

    assign pad_pu_o[g] = (pull == PULL_UP);
    assign pad_pd_o[g] = (pull == PULL_DOWN);
    assign alt_sel_o[NUM_ALT*g +: NUM_ALT] = sel;

    p_input_undriven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsel_i[FSEL_W*g +: FSEL_W] == 3'd0) |-> !pad_oe_o[g]);
    p_output_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsel_i[FSEL_W*g +: FSEL_W] == 3'd1) |-> (pad_oe_o[g] && pad_out_o[g] == out_i[g]));
    p_alt_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsel_i[FSEL_W*g +: FSEL_W] >= 3'd2) |->
        ($countones(alt_sel_o[NUM_ALT*g +: NUM_ALT]) == 1));
    p_no_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsel_i[FSEL_W*g +: FSEL_W] < 3'd2) |-> (alt_sel_o[NUM_ALT*g +: NUM_ALT] == '0));
  end
endmodule

// File: rtl/gpio_fsel_port.sv
module gpio_fsel_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_req_i,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  output logic                        bus_rvalid_o,
  input  logic [NUM_PINS-1:0]         pad_in_i,
  output logic [NUM_PINS-1:0]         pad_out_o,
  output logic [NUM_PINS-1:0]         pad_oe_o,
  output logic [NUM_PINS-1:0]         pad_pu_o,
  output logic [NUM_PINS-1:0]         pad_pd_o,
  output logic [NUM_PINS*6-1:0]       alt_sel_o,
  input  logic [NUM_PINS*6-1:0]       alt_out_i,
  input  logic [NUM_PINS*6-1:0]       alt_oe_i
);
  logic [NUM_PINS-1:0]        level;
  logic [NUM_PINS*FSEL_W-1:0] fsel;
  logic [NUM_PINS-1:0]        out_latch;
  logic [NUM_PINS*PULL_W-1:0] pull;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (pad_in_i),
    .dout_o (level)
  );

  gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .level_i      (level),
    .fsel_o       (fsel),
    .out_o        (out_latch),
    .pull_o       (pull)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fsel_i    (fsel),
    .out_i     (out_latch),
    .pull_i    (pull),
    .alt_out_i (alt_out_i),
    .alt_oe_i  (alt_oe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o),
    .pad_pu_o  (pad_pu_o),
    .pad_pd_o  (pad_pd_o),
    .alt_sel_o (alt_sel_o)
  );

  p_pull_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_pd_o) == '0);
endmodule

// File: tb/gpio_fsel_port_tb_top.sv
module gpio_fsel_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 18;
  localparam int AW = 8;
  localparam int NA = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          rvalid;
  logic [N-1:0]  pad_in, pad_out, pad_oe, pad_pu, pad_pd;
  logic [N*NA-1:0] alt_sel, alt_out, alt_oe;

  int checks = 0;
  int errors = 0;
  int mode_m [N];
  int pull_m [N];
  logic [N-1:0] lat_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_fsel_port #(.NUM_PINS(N), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pu_o(pad_pu), .pad_pd_o(pad_pd),
    .alt_sel_o(alt_sel), .alt_out_i(alt_out), .alt_oe_i(alt_oe)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R12 no valid after write", {rvalid, rdata}, 33'd0);
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    chk("R12 valid on read", rvalid, 1'b1);
    @(negedge clk);
    chk("R12 valid one cycle", {rvalid, rdata}, 33'd0);
  endtask

  function automatic logic [31:0] fsel_word(input int r);
    logic [31:0] w = '0;
    for (int p = 0; p < N; p++)
      if (p / 10 == r) w[3*(p%10) +: 3] = 3'(mode_m[p]);
    return w;
  endfunction

  function automatic logic [31:0] pull_word(input int r);
    logic [31:0] w = '0;
    for (int p = 0; p < N; p++)
      if (p / 16 == r) w[2*(p%16) +: 2] = 2'(pull_m[p]);
    return w;
  endfunction

  task automatic write_modes();
    for (int r = 0; r < 2; r++) bus_wr(r, fsel_word(r));
  endtask

  task automatic write_pulls();
    for (int r = 0; r < 2; r++) bus_wr(12 + r, pull_word(r));
  endtask

  task automatic check_pads(input string tag);
    logic [N-1:0]    e_out, e_oe, e_pu, e_pd;
    logic [N*NA-1:0] e_sel;
    e_sel = '0;
    for (int p = 0; p < N; p++) begin
      if (mode_m[p] < 2) begin
        e_out[p] = lat_m[p];
        e_oe[p]  = (mode_m[p] == 1);
      end else begin
        e_out[p] = alt_out[NA*p + mode_m[p] - 2];
        e_oe[p]  = alt_oe[NA*p + mode_m[p] - 2];
        e_sel[NA*p + mode_m[p] - 2] = 1'b1;
      end
      e_pu[p] = (pull_m[p] == 2);
      e_pd[p] = (pull_m[p] == 1);
    end
    chk({tag, " pad_oe"}, pad_oe, e_oe);
    chk({tag, " pad_out"}, pad_out, e_out);
    chk({tag, " alt_sel"}, alt_sel, e_sel);
    chk({tag, " pulls R10"}, {pad_pu, pad_pd}, {e_pu, e_pd});
  endtask

  task automatic all_modes(input int m);
    for (int p = 0; p < N; p++) mode_m[p] = m;
    write_modes();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] v, old;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    pad_in = '0; alt_out = '0; alt_oe = '0;
    for (int p = 0; p < N; p++) begin mode_m[p] = 0; pull_m[p] = 0; end
    lat_m = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {pad_oe, pad_out, pad_pu, pad_pd, alt_sel, rvalid, rdata}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {pad_oe, pad_out, pad_pu, pad_pd, alt_sel, rvalid, rdata}, '0);

    // R2: field packing and unused bits
    bus_wr(0, 32'hFFFF_FFFF);
    bus_wr(1, 32'hFFFF_FFFF);
    bus_rd(0, d); chk("R2 word0 readback", d, 32'h3FFF_FFFF);
    bus_rd(1, d); chk("R2 word1 partial", d, 32'h00FF_FFFF);

    // R5/R7: every pin through every code, rotating
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < N; p++) mode_m[p] = (p + s) % 8;
      alt_out = {N*NA{1'b0}} | ({N*NA{1'b1}} / (s + 3));
      alt_oe  = ~alt_out ^ (alt_out << s);
      write_modes();
      check_pads("R5 R7 mode sweep");
      bus_rd(0, d); chk("R2 sweep word0", d, fsel_word(0));
      bus_rd(1, d); chk("R2 sweep word1", d, fsel_word(1));
    end

    // R3/R4: set/clear in output mode
    all_modes(1);
    check_pads("R1 latch zero in output");
    bus_wr(8, 32'h0002_F0F3); lat_m |= 18'h2F0F3;
    check_pads("R3 set pattern");
    bus_wr(8, 32'h0); check_pads("R3 zero set no effect");
    bus_wr(9, 32'h0001_00F0); lat_m &= ~18'h100F0;
    check_pads("R4 clear pattern");
    bus_wr(9, 32'h0); check_pads("R4 zero clear no effect");
    bus_wr(9, 32'hFFFF_FFFF); lat_m = '0;
    for (int p = 0; p < N; p++) begin
      bus_wr(8, 32'(1) << p); lat_m[p] = 1'b1;
      chk("R3 walking set", pad_out, lat_m);
    end
    for (int p = 0; p < N; p++) begin
      bus_wr(9, 32'(1) << p); lat_m[p] = 1'b0;
      chk("R4 walking clear", pad_out, lat_m);
    end

    // R6: latch updates while in input mode, driven on switch
    all_modes(0);
    bus_wr(8, 32'h0003_3C3C); lat_m |= 18'h33C3C;
    bus_wr(9, 32'h0000_0C00); lat_m &= ~18'h00C00;
    chk("R5 input no drive", pad_oe, '0);
    bus_wr(0, 32'h0); bus_wr(12, 32'h0);
    chk("R6 other writes keep latch", pad_out, lat_m);
    all_modes(1);
    chk("R6 output drives retained", pad_out, lat_m);
    chk("R5 output enable", pad_oe, {N{1'b1}});

    // R11: write-only and unmapped reads
    bus_rd(8, d);  chk("R11 set reads zero", d, 32'h0);
    bus_rd(9, d);  chk("R11 clear reads zero", d, 32'h0);
    bus_rd(7, d);  chk("R11 unmapped reads zero", d, 32'h0);
    bus_rd(32 + N, d); chk("R11 past last pin window", d, 32'h0);

    // R10: pull codes
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < N; p++) pull_m[p] = (p + s) % 4;
      write_pulls();
      check_pads("R10 pull sweep");
      bus_rd(12, d); chk("R10 pull word0", d, pull_word(0));
      bus_rd(13, d); chk("R10 pull word1", d, pull_word(1));
    end

    // R8: synchronizer latency, R9: per-pin window
    for (int i = 0; i < 6; i++) begin
      old = pad_in;
      v = N'((i + 1) * 32'h9E37 ^ (32'h2AAAA >> i));
      @(negedge clk);
      pad_in = v; req = 1'b1; we = 1'b0; addr = AW'(10);
      @(negedge clk); chk("R8 first edge old", rdata, 32'(old));
      @(negedge clk); chk("R8 second edge old", rdata, 32'(old));
      @(negedge clk); chk("R8 third edge new", rdata, 32'(v));
      req = 1'b0;
      for (int p = 0; p < N; p++) begin
        bus_rd(32 + p, d);
        chk("R9 pin window", d, 32'(v[p]));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule